// File: doc/BRIEF.md
# Cache Coherence Directory Controller

This block is the home-node directory for a small shared-memory system built from several caching nodes. For every cache block it owns, it holds a coherence state and a presence vector with one bit per node. Requests arrive one at a time. Each request carries a kind (read, read-for-ownership, upgrade), the node that asks and the block index. The controller looks up the block's entry and rewrites it in the same cycle. It then issues the coherence messages that the transition calls for: a data reply, a plain grant, invalidations or an intervention. These go only to the nodes whose presence bits are set, and are never broadcast.

Block data comes from a local backing array with one cycle of read latency. While the messages for one request are still being delivered, the controller stalls the request port. This makes it the single ordering point for every block it homes.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every entry is Uncached with an empty presence vector, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read or read-for-ownership to an Uncached block produces one data reply to the requestor. The entry becomes Exclusive/Modified with the requestor as its only owner.
- R3: A read to an Exclusive/Modified block sends one intervention to the owner and nothing to the requestor. The entry becomes Shared, and its presence vector holds both the owner and the requestor.
- R4: A read-for-ownership to an Exclusive/Modified block sends one invalidation to the old owner and nothing else. The requestor becomes the only owner and the state stays Exclusive/Modified.
- R5: A read to a Shared block sends a data reply to the requestor, adds the requestor to the presence vector and leaves the state Shared.
- R6: A read-for-ownership to a Shared block sends one invalidation whose destination mask holds every present node except the requestor, then a data reply. The entry becomes Exclusive/Modified with only the requestor present.
- R7: An upgrade to a Shared block sends the same invalidation as R6, then a grant with zero data. The entry becomes Exclusive/Modified with only the requestor present.
- R8: When a request yields both an invalidation or intervention and a reply, the invalidation or intervention goes out first. If its mask would be empty (the only node present is the requestor), that message is skipped.
- R9: `req_ready` is low from the cycle a request is accepted until its last message is taken. A message held with `msg_ready` low keeps `msg_valid` and all its fields unchanged.
- R10: Message kind codes are: 0 data reply, 1 grant, 2 invalidation, 3 intervention. Bit n of `msg_dest` addresses node n. Replies address only the requestor. Invalidations, interventions and grants carry zero data.
- R11: An upgrade to a block that is not Shared is handled as read-for-ownership. Request kind code 3 is handled as a read. The other request codes are 0 read, 1 read-for-ownership and 2 upgrade.
- R12: The data word of block b is 0xC0DE0000 XOR b, and it is carried by every data reply for that block, including replies for the highest block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | Request kind code |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Block index |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | Message kind code |
| msg_dest | output | NODES | Destination node mask |
| msg_blk | output | $clog2(BLOCKS) | Block index of the message |
| msg_data | output | DATA_W | Block data or zero |

## Verification
Two activities can fall into the same cycle. One is a stalled outgoing message still waiting on `msg_ready`. The other is a new request already held valid at the request port. The bench drives `msg_ready` low in a repeating pattern while the next request is pending, so a two-message transaction spans several stalls. It checks that the pending request is not accepted and that the stalled message's fields stay frozen. A scoreboard then confirms that the messages arrive in exactly the predicted order, with no extra or missing items.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DIR_U  = 2'd0,
        DIR_EM = 2'd1,
        DIR_S  = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        RQ_RD  = 2'd0,
        RQ_RDX = 2'd1,
        RQ_UPG = 2'd2,
        RQ_RSV = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_GRANT = 2'd1,
        MS_INV   = 2'd2,
        MS_INTV  = 2'd3
    } msg_kind_e;

endpackage

// File: rtl/coh_dir_mem.sv
module coh_dir_mem #(
    parameter int          BLOCKS   = 16,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] MEM_SALT = 32'hC0DE0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [$clog2(BLOCKS)-1:0] rd_blk,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int BLK_W = $clog2(BLOCKS);

    logic [DATA_W-1:0] data_d, data_q;

    function automatic logic [DATA_W-1:0] word_of(input logic [BLK_W-1:0] b);
        return DATA_W'(MEM_SALT) ^ DATA_W'(b);
    endfunction

    always_comb begin
        data_d = data_q;
        if (rd_en) data_d = word_of(rd_blk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign rd_data = data_q;
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] rd_blk,
    output dir_state_e                rd_st,
    output logic [NODES-1:0]          rd_vec,
    input  logic                      we,
    input  logic [$clog2(BLOCKS)-1:0] wr_blk,
    input  dir_state_e                wr_st,
    input  logic [NODES-1:0]          wr_vec
);
    dir_state_e       st_q  [BLOCKS];
    logic [NODES-1:0] vec_q [BLOCKS];

    for (genvar g = 0; g < BLOCKS; g++) begin : g_entry
        dir_state_e       st_d;
        logic [NODES-1:0] vec_d;

        always_comb begin
            st_d  = st_q[g];
            vec_d = vec_q[g];
            if (we && (wr_blk == $clog2(BLOCKS)'(g))) begin
                st_d  = wr_st;
                vec_d = wr_vec;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= DIR_U;
                vec_q[g] <= '0;
            end else begin
                st_q[g]  <= st_d;
                vec_q[g] <= vec_d;
            end
        end
    end

    assign rd_st  = st_q[rd_blk];
    assign rd_vec = vec_q[rd_blk];
endmodule

// File: rtl/coh_dir_next.sv
module coh_dir_next
    import coh_dir_pkg::*;
#(
    parameter int NODES = 8
) (
    input  dir_state_e               cur_st,
    input  logic [NODES-1:0]         cur_vec,
    input  req_kind_e                kind,
    input  logic [$clog2(NODES)-1:0] node,
    output dir_state_e               new_st,
    output logic [NODES-1:0]         new_vec,
    output logic                     fwd_en,
    output msg_kind_e                fwd_kind,
    output logic [NODES-1:0]         fwd_mask,
    output logic                     rsp_en,
    output msg_kind_e                rsp_kind
);
    logic [NODES-1:0] own, others;
    req_kind_e        eff;

    always_comb begin
        own    = NODES'(1) << node;
        others = cur_vec & ~own;
        eff    = kind;
        if (kind == RQ_RSV)                        eff = RQ_RD;
        else if (kind == RQ_UPG && cur_st != DIR_S) eff = RQ_RDX;

        new_st   = cur_st;
        new_vec  = cur_vec;
        fwd_en   = 1'b0;
        fwd_kind = MS_INV;
        fwd_mask = others;
        rsp_en   = 1'b0;
        rsp_kind = MS_DATA;

        case (cur_st)
            DIR_EM: begin
                fwd_en = |others;
                if (eff == RQ_RD) begin
                    fwd_kind = MS_INTV;
                    new_st   = DIR_S;
                    new_vec  = cur_vec | own;
                end else begin
                    new_vec  = own;
                end
            end
            DIR_S: begin
                rsp_en = 1'b1;
                if (eff == RQ_RD) begin
                    new_vec = cur_vec | own;
                end else begin
                    fwd_en  = |others;
                    new_st  = DIR_EM;
                    new_vec = own;
                    if (eff == RQ_UPG) rsp_kind = MS_GRANT;
                end
            end
            default: begin
                rsp_en  = 1'b1;
                new_st  = DIR_EM;
                new_vec = own;
            end
        endcase
    end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int          NODES    = 8,
    parameter int          BLOCKS   = 16,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] MEM_SALT = 32'hC0DE0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_kind,
    input  logic [$clog2(NODES)-1:0]  req_node,
    input  logic [$clog2(BLOCKS)-1:0] req_blk,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [1:0]                msg_kind,
    output logic [NODES-1:0]          msg_dest,
    output logic [$clog2(BLOCKS)-1:0] msg_blk,
    output logic [DATA_W-1:0]         msg_data
);
    localparam int BLK_W = $clog2(BLOCKS);

    typedef struct packed {
        logic             fwd_pend;
        msg_kind_e        fwd_kind;
        logic [NODES-1:0] fwd_mask;
        logic             rsp_pend;
        msg_kind_e        rsp_kind;
        logic [NODES-1:0] rsp_mask;
        logic [BLK_W-1:0] blk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              busy, accept, take;
    dir_state_e        tb_st, nx_st;
    logic [NODES-1:0]  tb_vec, nx_vec, nx_fwd_mask;
    logic              nx_fwd_en, nx_rsp_en;
    msg_kind_e         nx_fwd_kind, nx_rsp_kind;
    logic [DATA_W-1:0] mem_data;

    assign busy   = ctl_q.fwd_pend | ctl_q.rsp_pend;
    assign accept = req_valid & ~busy;
    assign take   = busy & msg_ready;

    coh_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_blk (req_blk),
        .rd_st  (tb_st),
        .rd_vec (tb_vec),
        .we     (accept),
        .wr_blk (req_blk),
        .wr_st  (nx_st),
        .wr_vec (nx_vec)
    );

    coh_dir_next #(.NODES(NODES)) u_next (
        .cur_st   (tb_st),
        .cur_vec  (tb_vec),
        .kind     (req_kind_e'(req_kind)),
        .node     (req_node),
        .new_st   (nx_st),
        .new_vec  (nx_vec),
        .fwd_en   (nx_fwd_en),
        .fwd_kind (nx_fwd_kind),
        .fwd_mask (nx_fwd_mask),
        .rsp_en   (nx_rsp_en),
        .rsp_kind (nx_rsp_kind)
    );

    coh_dir_mem #(.BLOCKS(BLOCKS), .DATA_W(DATA_W), .MEM_SALT(MEM_SALT)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (accept),
        .rd_blk  (req_blk),
        .rd_data (mem_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (take) begin
            if (ctl_q.fwd_pend) ctl_d.fwd_pend = 1'b0;
            else                ctl_d.rsp_pend = 1'b0;
        end
        if (accept) begin
            ctl_d.fwd_pend = nx_fwd_en;
            ctl_d.fwd_kind = nx_fwd_kind;
            ctl_d.fwd_mask = nx_fwd_mask;
            ctl_d.rsp_pend = nx_rsp_en;
            ctl_d.rsp_kind = nx_rsp_kind;
            ctl_d.rsp_mask = NODES'(1) << req_node;
            ctl_d.blk      = req_blk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = ~busy;
    assign msg_valid = busy;
    assign msg_kind  = ctl_q.fwd_pend ? ctl_q.fwd_kind : ctl_q.rsp_kind;
    assign msg_dest  = ctl_q.fwd_pend ? ctl_q.fwd_mask : ctl_q.rsp_mask;
    assign msg_blk   = ctl_q.blk;
    assign msg_data  = (ctl_q.fwd_pend || ctl_q.rsp_kind != MS_DATA) ? '0 : mem_data;
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
    parameter int NODES  = 8,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [$clog2(NODES)-1:0]  req_node,
    input logic                      msg_valid,
    input logic                      msg_ready,
    input logic [1:0]                msg_kind,
    input logic [NODES-1:0]          msg_dest,
    input logic [$clog2(BLOCKS)-1:0] msg_blk,
    input logic [DATA_W-1:0]         msg_data
);
    logic [$clog2(NODES)-1:0] asker_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      asker_q <= '0;
        else if (req_valid && req_ready) asker_q <= req_node;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                    && $stable(msg_blk) && $stable(msg_data));

    assert_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && req_ready));

    assert_fwd_skips_asker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind[1] |-> msg_dest[asker_q] == 1'b0 && msg_dest != '0);

    assert_reply_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_kind[1] |-> msg_dest == (NODES'(1) << asker_q));

    assert_intv_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind == 2'd3 |-> $onehot(msg_dest));

    assert_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind != 2'd0 |-> msg_data == '0);
endmodule

bind coh_dir_ctrl coh_dir_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_node  (req_node),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_dest  (msg_dest),
    .msg_blk   (msg_blk),
    .msg_data  (msg_data)
);

// File: tb/coh_dir_ctrl_bench.sv
module coh_dir_ctrl_bench;
    localparam int NODES  = 8;
    localparam int BLOCKS = 16;
    localparam int DATA_W = 32;
    localparam int NW = $clog2(NODES);
    localparam int BW = $clog2(BLOCKS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [NW-1:0]     req_node = '0;
    logic [BW-1:0]     req_blk = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [1:0]        msg_kind;
    logic [NODES-1:0]  msg_dest;
    logic [BW-1:0]     msg_blk;
    logic [DATA_W-1:0] msg_data;

    always #2.5 clk = ~clk;

    coh_dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_coh_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_blk(msg_blk), .msg_data(msg_data)
    );

    typedef struct {
        logic [1:0]        kind;
        logic [NODES-1:0]  dest;
        logic [BW-1:0]     blk;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    bit   run      = 1'b0;
    int   m_st [BLOCKS];
    logic [NODES-1:0] m_vec [BLOCKS];

    function automatic logic [DATA_W-1:0] word_of(input int b);
        return 32'hC0DE0000 ^ DATA_W'(b);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void push(input logic [1:0] k, input logic [NODES-1:0] d,
                                 input int b, input logic [DATA_W-1:0] w, input string tag);
        exp_t e;
        e.kind = k; e.dest = d; e.blk = BW'(b); e.data = w; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // model of R2..R8, R11: state 0 U, 1 EM, 2 S
    task automatic do_req(input logic [1:0] k, input int n, input int b, input string tag);
        logic [NODES-1:0] me, oth;
        int eff;
        me  = NODES'(1) << n;
        oth = m_vec[b] & ~me;
        eff = (k == 2'd3) ? 0 : int'(k);
        if (eff == 2 && m_st[b] != 2) eff = 1;
        case (m_st[b])
            1: begin
                if (oth != 0) push((eff == 0) ? 2'd3 : 2'd2, oth, b, '0, tag);
                if (eff == 0) begin m_st[b] = 2; m_vec[b] = m_vec[b] | me; end
                else m_vec[b] = me;
            end
            2: begin
                if (eff == 0) begin
                    push(2'd0, me, b, word_of(b), tag);
                    m_vec[b] = m_vec[b] | me;
                end else begin
                    if (oth != 0) push(2'd2, oth, b, '0, tag);
                    push((eff == 2) ? 2'd1 : 2'd0, me, b, (eff == 2) ? '0 : word_of(b), tag);
                    m_st[b] = 1; m_vec[b] = me;
                end
            end
            default: begin
                push(2'd0, me, b, word_of(b), tag);
                m_st[b] = 1; m_vec[b] = me;
            end
        endcase
        req_kind = k; req_node = NW'(n); req_blk = BW'(b); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor + msg_ready pattern, all at the falling edge
    int               cyc = 0;
    bit               stalled = 1'b0;
    logic [1:0]       s_kind;
    logic [NODES-1:0] s_dest;
    logic [BW-1:0]    s_blk;
    logic [DATA_W-1:0] s_data;

    always @(negedge clk) begin
        if (run) begin
            cyc++;
            if (stalled) begin
                check(msg_valid && msg_kind == s_kind && msg_dest == s_dest &&
                      msg_blk == s_blk && msg_data == s_data,
                      "R9", "held message changed", longint'(msg_dest), longint'(s_dest));
            end
            msg_ready = (cyc % 3) != 0;
            stalled = 1'b0;
            if (msg_valid) begin
                check(!req_ready, "R9", "req_ready during message", longint'(req_ready), 0);
                if (!msg_ready) begin
                    stalled = 1'b1;
                    s_kind = msg_kind; s_dest = msg_dest; s_blk = msg_blk; s_data = msg_data;
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected message", longint'(msg_kind), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(msg_kind == e.kind, e.tag, "kind", longint'(msg_kind), longint'(e.kind));
                    check(msg_dest == e.dest, e.tag, "dest", longint'(msg_dest), longint'(e.dest));
                    check(msg_blk  == e.blk,  e.tag, "blk",  longint'(msg_blk),  longint'(e.blk));
                    // R10 / R12: data word
                    check(msg_data == e.data, e.tag, "data", longint'(msg_data), longint'(e.data));
                end
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < BLOCKS; i++) begin m_st[i] = 0; m_vec[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
        check(msg_valid == 1'b0, "R1", "msg_valid after reset", longint'(msg_valid), 0);
        run = 1'b1;

        do_req(2'd0, 1, 3, "R2");          // U read
        do_req(2'd0, 2, 3, "R3");          // EM read -> intervention to 1
        do_req(2'd0, 4, 3, "R5");          // S read
        do_req(2'd2, 2, 3, "R7");          // S upgrade -> inv {1,4}, grant
        do_req(2'd1, 5, 3, "R4");          // EM rdx -> inv to 2
        do_req(2'd1, 6, 7, "R2");          // U rdx
        do_req(2'd0, 0, 7, "R3");
        do_req(2'd0, 3, 7, "R5");
        do_req(2'd1, 5, 7, "R6");          // S rdx -> inv {6,0,3}, data
        do_req(2'd1, 5, 7, "R8");          // EM rdx by owner: no message
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && req_ready, "R8", "skipped message state",
              longint'(exp_q.size()), 0);
        do_req(2'd2, 2, 9, "R11");         // upgrade on U acts as rdx
        do_req(2'd3, 7, 9, "R11");         // code 3 acts as read
        do_req(2'd0, 7, 1, "R1");          // fresh block still Uncached
        do_req(2'd0, 0, 1, "R3");
        do_req(2'd2, 0, 1, "R7");          // upgrade by sharer: inv to 7 only
        do_req(2'd0, 4, BLOCKS-1, "R12");  // highest block
        do_req(2'd0, 4, 0, "R12");
        do_req(2'd0, 6, 0, "R3");
        do_req(2'd0, 4, 0, "R5");          // read by sharer already present
        do_req(2'd1, 4, 0, "R6");          // inv to 6 only
        drain();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "pending expected messages", longint'(exp_q.size()), 0);
        finish_run();
    end
endmodule